// File: doc/BRIEF.md
# Strobe Delay-Code Controller with Dual Offset Trim

This block is the digital half of a delay-locked loop that phase-shifts data strobes. A phase detector outside the block reports, on cycles it qualifies with an enable, whether the delay should grow or shrink. The block keeps a 6-bit delay code and steps it by one on each qualified cycle. The code goes unchanged to the delay chains and to other consumers.

Two trim units each take the delay code and make an adjusted copy for one group of strobe pins. Each unit has its own 6-bit trim amount and its own add/subtract select. Trimmed results clamp to the code range. Each trimmed output is registered.

Either of two active-low resets restarts the loop: one from the core and one from a pin. After a reset is released, a ready flag stays low for a fixed settling period. Until the flag rises, captured data must not be trusted.

Top module: `dll_delay_ctrl`

## Requirements
- R1: While `core_rst_n` or `pin_rst_n` is low (either one alone is enough), the next clock edge sets `dly_code` to 32 and `lock_ready` to 0.
- R2: On an edge where `pd_en` is 1, `dly_code` goes up by one if `pd_up` is 1 and down by one if `pd_up` is 0. On an edge where `pd_en` is 0, `dly_code` holds.
- R3: `dly_code` saturates. An up step at 63 leaves it at 63, and a down step at 0 leaves it at 0. It never wraps.
- R4: Count the clock edges with both resets high, starting at 1 for the first edge after release. `lock_ready` is 0 after edges 1 to 1279 and becomes 1 at edge 1280. It then stays 1 until the next reset.
- R5: Trim unit A works as follows. With `sub_a` = 0, `strobe_adj_a` becomes min(code + `off_a`, 63). With `sub_a` = 1, it becomes max(code − `off_a`, 0).
- R6: Trim unit B does the same with `off_b`, `sub_b` and `strobe_adj_b`. Unit B is independent of unit A's inputs.
- R7: Both trimmed outputs are registered. A change to the code, the trim amount or the select shows at the output after the next clock edge, and not before it.
- R8: `dly_code` is the untrimmed counter value. Trim inputs never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| core_rst_n | input | 1 | Core-side reset, active low, synchronous |
| pin_rst_n | input | 1 | Pin-side reset, active low, synchronous |
| pd_up | input | 1 | Phase detector direction: 1 = longer delay |
| pd_en | input | 1 | Phase detector qualifier; the code moves only when this is high |
| off_a | input | 6 | Trim amount for unit A |
| sub_a | input | 1 | Unit A select: 1 = subtract, 0 = add |
| off_b | input | 6 | Trim amount for unit B |
| sub_b | input | 1 | Unit B select: 1 = subtract, 0 = add |
| dly_code | output | 6 | Untrimmed delay code to the delay chains |
| strobe_adj_a | output | 6 | Trimmed code for strobe group A |
| strobe_adj_b | output | 6 | Trimmed code for strobe group B |
| lock_ready | output | 1 | High once the settling period after reset has elapsed |

## Verification
The hardest cases to reach are the trim clamps at the ends of the code range. These need the counter at exactly 0 or 63, and the only way to get there is to walk it with the phase detector inputs. The bench first drives long runs of up steps and down steps to park the code at each end and at several points in between. It then sweeps every trim amount with both selects, giving the two units mirrored settings so that one clamps while the other does not. The ready timing is checked at the edges on either side of the 1280th edge, after both kinds of reset.

// File: rtl/dll_ctl_pkg.sv
package dll_ctl_pkg;
    localparam int CODE_W = 6;
    localparam int N_TRIM = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t code;
    } ctr_state_t;

    typedef struct packed {
        code_t adj;
    } trim_state_t;
endpackage

// File: rtl/dll_code_counter.sv
module dll_code_counter
    import dll_ctl_pkg::*;
#(
    parameter int    W         = CODE_W,
    parameter logic [W-1:0] INIT_CODE = W'(32)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         step_up,
    output logic [W-1:0] code_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        if (rst) begin
            code_d = INIT_CODE;
        end else if (step_en) begin
            if (step_up && code_q != TOP)
                code_d = code_q + W'(1);
            else if (!step_up && code_q != '0)
                code_d = code_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        code_q <= code_d;
    end

    assign code_o = code_q;

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(code_q));
    // R3
    top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_up && code_q == TOP) |=> code_q == TOP);
    // R3
    bottom_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_up && code_q == '0) |=> code_q == '0);
    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_en |=> ($countones(code_q ^ $past(code_q)) >= 0) &&
                    ((code_q == $past(code_q) + W'(1)) ||
                     (code_q == $past(code_q) - W'(1)) ||
                     (code_q == $past(code_q))));
endmodule

// File: rtl/dll_settle_timer.sv
module dll_settle_timer #(
    parameter int SETTLE_CYCLES = 1280
) (
    input  logic clk,
    input  logic rst,
    output logic ready_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else begin
            if (st_q.cnt != LAST)
                st_d.cnt = st_q.cnt + CNT_W'(1);
            st_d.ready = (st_q.cnt >= LAST - CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ready_o = st_q.ready;

    // R4
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.ready |=> st_q.ready);
    // R4
    ready_rise_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.ready) |-> st_q.cnt == LAST);
endmodule

// File: rtl/dll_trim_unit.sv
module dll_trim_unit
    import dll_ctl_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] trim_i,
    input  logic         sub_i,
    output logic [W-1:0] adj_o
);
    logic [W-1:0] adj_d, adj_q;
    logic [W:0]   sum_w, diff_w;

    always_comb begin
        sum_w  = {1'b0, code_i} + {1'b0, trim_i};
        diff_w = {1'b0, code_i} - {1'b0, trim_i};
        if (rst)
            adj_d = '0;
        else if (sub_i)
            adj_d = diff_w[W] ? '0 : diff_w[W-1:0];
        else
            adj_d = sum_w[W] ? {W{1'b1}} : sum_w[W-1:0];
    end

    always_ff @(posedge clk) begin
        adj_q <= adj_d;
    end

    assign adj_o = adj_q;

    // R5
    add_not_below_chk: assert property (@(posedge clk) disable iff (rst)
        !sub_i |=> adj_q >= $past(code_i));
    // R5
    sub_not_above_chk: assert property (@(posedge clk) disable iff (rst)
        sub_i |=> adj_q <= $past(code_i));
    // R7
    zero_trim_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (trim_i == '0) |=> adj_q == $past(code_i));
endmodule

// File: rtl/dll_delay_ctrl.sv
module dll_delay_ctrl
    import dll_ctl_pkg::*;
#(
    parameter int SETTLE_CYCLES = 1280,
    parameter int RESET_CODE    = 32
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              pin_rst_n,
    input  logic              pd_up,
    input  logic              pd_en,
    input  logic [CODE_W-1:0] off_a,
    input  logic              sub_a,
    input  logic [CODE_W-1:0] off_b,
    input  logic              sub_b,
    output logic [CODE_W-1:0] dly_code,
    output logic [CODE_W-1:0] strobe_adj_a,
    output logic [CODE_W-1:0] strobe_adj_b,
    output logic              lock_ready
);
    logic rst_any;
    assign rst_any = !core_rst_n || !pin_rst_n;

    code_t code_w;
    code_t trim_amt [N_TRIM];
    logic  trim_sub [N_TRIM];
    code_t trim_out [N_TRIM];

    assign trim_amt[0] = off_a;
    assign trim_amt[1] = off_b;
    assign trim_sub[0] = sub_a;
    assign trim_sub[1] = sub_b;

    dll_code_counter #(
        .W         (CODE_W),
        .INIT_CODE (CODE_W'(RESET_CODE))
    ) u_ctr (
        .clk     (clk),
        .rst     (rst_any),
        .step_en (pd_en),
        .step_up (pd_up),
        .code_o  (code_w)
    );

    dll_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst_any),
        .ready_o (lock_ready)
    );

    for (genvar g = 0; g < N_TRIM; g++) begin : g_trim
        dll_trim_unit #(.W(CODE_W)) u_trim (
            .clk    (clk),
            .rst    (rst_any),
            .code_i (code_w),
            .trim_i (trim_amt[g]),
            .sub_i  (trim_sub[g]),
            .adj_o  (trim_out[g])
        );
    end

    assign dly_code     = code_w;
    assign strobe_adj_a = trim_out[0];
    assign strobe_adj_b = trim_out[1];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst_any |=> (dly_code == CODE_W'(RESET_CODE)) && !lock_ready);
endmodule

// File: tb/dll_delay_ctrl_bench.sv
module dll_delay_ctrl_bench;
    logic       clk = 1'b0;
    logic       core_rst_n, pin_rst_n, pd_up, pd_en, sub_a, sub_b;
    logic [5:0] off_a, off_b;
    logic [5:0] dly_code, strobe_adj_a, strobe_adj_b;
    logic       lock_ready;

    int n_cmp = 0;
    int n_bad = 0;
    int model_code;

    always #5 clk = ~clk;

    dll_delay_ctrl u_dll_delay_ctrl (
        .clk(clk), .core_rst_n(core_rst_n), .pin_rst_n(pin_rst_n),
        .pd_up(pd_up), .pd_en(pd_en),
        .off_a(off_a), .sub_a(sub_a), .off_b(off_b), .sub_b(sub_b),
        .dly_code(dly_code), .strobe_adj_a(strobe_adj_a),
        .strobe_adj_b(strobe_adj_b), .lock_ready(lock_ready)
    );

    function automatic int trim(input int c, input int o, input logic s);
        int r;
        r = s ? c - o : c + o;
        if (r < 0) r = 0;
        if (r > 63) r = 63;
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock edge; inputs are changed and outputs sampled at negedges
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step_code(input logic up, input int n);
        pd_en = 1'b1;
        pd_up = up;
        for (int i = 0; i < n; i++) begin
            tick();
            if (up) model_code = (model_code < 63) ? model_code + 1 : 63;
            else    model_code = (model_code > 0) ? model_code - 1 : 0;
            check(up ? "R3 up/sat" : "R3 down/sat", dly_code, model_code);
        end
        pd_en = 1'b0;
    endtask

    task automatic settle_check(input string tag);
        for (int k = 1; k <= 1282; k++) begin
            tick();
            if (k >= 1278) check({"R4 ", tag}, lock_ready, (k >= 1280) ? 1 : 0);
        end
    endtask

    task automatic trim_sweep();
        for (int s = 0; s < 2; s++) begin
            for (int o = 0; o < 64; o++) begin
                off_a = 6'(o);
                sub_a = s[0];
                off_b = 6'(63 - o);
                sub_b = !s[0];
                tick();
                check("R5 unit A", strobe_adj_a, trim(model_code, o, s[0]));
                check("R6 unit B", strobe_adj_b, trim(model_code, 63 - o, !s[0]));
                check("R8 code untouched", dly_code, model_code);
            end
        end
    endtask

    initial begin
        #(200_000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        core_rst_n = 1'b0; pin_rst_n = 1'b1;
        pd_up = 1'b0; pd_en = 1'b0;
        off_a = '0; off_b = '0; sub_a = 1'b0; sub_b = 1'b0;
        @(negedge clk);
        tick(); tick();
        model_code = 32;
        check("R1 core reset code", dly_code, 32);
        check("R1 core reset ready", lock_ready, 0);

        // release; code must hold with pd_en low (R2), ready timing (R4)
        pd_up = 1'b1;
        core_rst_n = 1'b1;
        settle_check("after core reset");
        check("R2 hold without enable", dly_code, 32);

        // R2 / R3: walk up past top, down past bottom
        step_code(1'b1, 40);
        trim_sweep();
        step_code(1'b0, 70);
        trim_sweep();

        // R2: mixed pattern with enable gaps
        for (int i = 0; i < 30; i++) begin
            pd_en = (i % 3 != 0);
            pd_up = (i % 5 < 3);
            tick();
            if (pd_en) model_code = pd_up ? ((model_code < 63) ? model_code + 1 : 63)
                                          : ((model_code > 0) ? model_code - 1 : 0);
            check("R2 mixed steps", dly_code, model_code);
        end
        pd_en = 1'b0;
        step_code(1'b1, 17);
        trim_sweep();

        // R7: output unchanged before the edge, updated after it
        off_a = 6'd0; sub_a = 1'b0; off_b = 6'd0; sub_b = 1'b0;
        tick();
        off_a = 6'd5; sub_a = 1'b1;
        off_b = 6'd3;
        #1;
        check("R7 A before edge", strobe_adj_a, model_code);
        check("R7 B before edge", strobe_adj_b, model_code);
        tick();
        check("R7 A after edge", strobe_adj_a, trim(model_code, 5, 1'b1));
        check("R7 B after edge", strobe_adj_b, trim(model_code, 3, 1'b0));
        pd_en = 1'b1; pd_up = 1'b1;
        tick();
        pd_en = 1'b0;
        model_code = (model_code < 63) ? model_code + 1 : 63;
        check("R7 A lags code", strobe_adj_a, trim(model_code - 1, 5, 1'b1));
        tick();
        check("R7 A follows code", strobe_adj_a, trim(model_code, 5, 1'b1));

        // R1: pin reset alone
        pin_rst_n = 1'b0;
        tick();
        model_code = 32;
        check("R1 pin reset code", dly_code, 32);
        check("R1 pin reset ready", lock_ready, 0);
        pin_rst_n = 1'b1;
        settle_check("after pin reset");
        trim_sweep();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule